// File: doc/BRIEF.md
# Predicated Vector Prefetch Address Sequencer

The sequencer accepts one contiguous prefetch request for 64-bit vector elements. The request arrives as a 32-bit instruction word together with the value of the selected general-purpose register, the stack pointer value and the governing predicate value. The block checks the fixed opcode bits of the word and decodes the signed vector-count offset, the base-register selector and the hint operation. It forms the starting byte address and then walks the vector one element per cycle. For each element whose predicate lane is set, it offers a prefetch hint on a valid/ready output. The hint carries the address and its read/write, cache-level and streaming attributes.

The vector length in bits is a parameter, so the element count is that length divided by 64. The predicate holds one bit per byte of vector. An inactive element produces no hint, but it still uses its 8-byte address slot and one cycle of the walk. The register selectors are decoded straight from the incoming word, so that the surrounding register file can supply the matching operand values in the same cycle.

Top module: `vec_prefetch_seq`

## Requirements
- R1: A request whose bits [31:22] are not 1000010111, whose bits [15:13] are not 011, or whose bit 4 is not 0 raises illegal_o for exactly the cycle after acceptance. It produces no hint and no done pulse, and the block stays idle.
- R2: The signed offset in bits [21:16] (range -32..31) counts whole vectors. Element 0's address is base + offset*ELEMS*8, wrapping modulo 2^64.
- R3: When bits [9:5] equal 31 the base is sp_i, otherwise gpr_i. The outputs rd_rn_o and rd_pg_o always show bits [9:5] and [12:10] of insn_i.
- R4: Elements are visited in ascending order. Element e has address start + 8*e whatever the predicate bits below it.
- R5: A hint for element e is offered only when pred_i bit 8*e was 1 at acceptance. The other seven bits of each byte group have no effect.
- R6: Each hint reports the raw 4-bit operation code (bits [3:0]) on hint_op_o. It also reports hint_write_o = code bit 3 (1 = write), hint_level_o = code bits [2:1] (0 = L1, 1 = L2, 2 = L3) and hint_stream_o = code bit 0 (1 = streaming).
- R7: Codes whose bits [2:1] are 11 are still issued as hints, with hint_named_o = 0. For all other codes hint_named_o = 1.
- R8: While hint_valid_o is high and hint_ready_i is low, the hint and all its attributes hold steady.
- R9: done_o is high for one cycle, in the cycle after the last element is handled, including when no element is active.
- R10: req_ready_o is high exactly when no walk is in progress. It is never high together with hint_valid_o.
- R11: With hint_ready_i held high, a legal request completes with done_o at the (ELEMS+1)-th cycle after acceptance, whatever the predicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request taken on valid and ready |
| insn_i | input | 32 | Instruction word |
| gpr_i | input | 64 | Value of the register named by rd_rn_o |
| sp_i | input | 64 | Stack pointer value |
| pred_i | input | VEC_BITS/8 | Governing predicate, one bit per vector byte |
| rd_rn_o | output | 5 | Base register selector decoded from insn_i |
| rd_pg_o | output | 3 | Predicate register selector decoded from insn_i |
| hint_valid_o | output | 1 | Hint offered |
| hint_ready_i | input | 1 | Hint taken |
| hint_addr_o | output | 64 | Hint byte address |
| hint_write_o | output | 1 | 1 = write prefetch, 0 = read |
| hint_level_o | output | 2 | Target cache level code |
| hint_stream_o | output | 1 | 1 = streaming, 0 = keep |
| hint_op_o | output | 4 | Raw operation code |
| hint_named_o | output | 1 | 0 for the unnamed code pattern |
| done_o | output | 1 | Walk finished pulse |
| illegal_o | output | 1 | Bad encoding pulse |

## Verification
Two cases are the hardest to reach from the ports. The first is a stall on an active element that sits right after a run of inactive ones, where the held address must already include the skipped slots. The second is a predicate whose only set bits lie outside the element lanes. The stimulus throttles hint_ready_i at random across many random predicates and all sixteen operation codes. It also adds directed predicates with only off-lane bits set, the offsets at both ends of the range, and a base near the top of the address space so that the start address wraps.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
  localparam logic [9:0] OPC_HI = 10'b1000010111;
  localparam logic [2:0] OPC_MID = 3'b011;

  typedef struct packed {
    logic       write;
    logic [1:0] level;
    logic       stream;
    logic [3:0] op;
    logic       named;
  } hint_attr_t;

  typedef struct packed {
    logic       legal;
    logic [5:0] imm;
    logic [2:0] pg;
    logic [4:0] rn;
    hint_attr_t attr;
  } dec_t;

  typedef enum logic {ST_IDLE, ST_WALK} walk_st_e;
endpackage

// File: rtl/vpf_decode.sv
module vpf_decode
  import vpf_pkg::*;
(
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  logic [3:0] op;
  assign op = insn_i[3:0];

  always_comb begin
    dec_o.legal       = (insn_i[31:22] == OPC_HI) && (insn_i[15:13] == OPC_MID) && !insn_i[4];
    dec_o.imm         = insn_i[21:16];
    dec_o.pg          = insn_i[12:10];
    dec_o.rn          = insn_i[9:5];
    dec_o.attr.write  = op[3];
    dec_o.attr.level  = op[2:1];
    dec_o.attr.stream = op[0];
    dec_o.attr.op     = op;
    dec_o.attr.named  = (op[2:1] != 2'b11);
  end
endmodule

// File: rtl/vpf_addr_gen.sv
module vpf_addr_gen #(
  parameter int ELEMS = 8
) (
  input  logic [63:0] gpr_i,
  input  logic [63:0] sp_i,
  input  logic [4:0]  rn_i,
  input  logic [5:0]  imm_i,
  output logic [63:0] start_o
);
  localparam logic [63:0] ELEMS_W = 64'(ELEMS);

  logic [63:0] base;
  logic [63:0] imm_ext;
  logic [63:0] off;

  assign base    = (rn_i == 5'd31) ? sp_i : gpr_i;
  assign imm_ext = {{58{imm_i[5]}}, imm_i};
  // modulo-2^64 product equals the signed product
  assign off     = (imm_ext * ELEMS_W) << 3;
  assign start_o = base + off;
endmodule

// File: rtl/vpf_lane_pick.sv
module vpf_lane_pick #(
  parameter int ELEMS = 8,
  localparam int PW = ELEMS * 8
) (
  input  logic [PW-1:0]    pred_i,
  output logic [ELEMS-1:0] mask_o
);
  for (genvar e = 0; e < ELEMS; e++) begin : g_lane
    assign mask_o[e] = pred_i[e*8];
  end

  logic unused_pred;
  assign unused_pred = ^pred_i;
endmodule

// File: rtl/vpf_walker.sv
module vpf_walker
  import vpf_pkg::*;
#(
  parameter int ELEMS = 8,
  localparam int IDX_W = (ELEMS > 1) ? $clog2(ELEMS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             legal_i,
  input  logic [63:0]      start_i,
  input  logic [ELEMS-1:0] mask_i,
  input  hint_attr_t       attr_i,
  output logic             idle_o,
  output logic             hint_valid_o,
  input  logic             hint_ready_i,
  output logic [63:0]      hint_addr_o,
  output hint_attr_t       hint_attr_o,
  output logic             done_o,
  output logic             illegal_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ELEMS - 1);

  walk_st_e         st_q;
  logic [63:0]      addr_q;
  logic [ELEMS-1:0] mask_q;
  logic [IDX_W-1:0] idx_q;
  hint_attr_t       attr_q;
  logic             done_q, ill_q;

  logic accept, act, adv, last;

  assign idle_o = (st_q == ST_IDLE);
  assign accept = req_valid_i && idle_o;
  assign act    = mask_q[idx_q];
  assign last   = (idx_q == LAST);
  // inactive lanes step without waiting on the consumer
  assign adv    = (st_q == ST_WALK) && (!act || hint_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      mask_q <= '0;
      idx_q  <= '0;
      attr_q <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      ill_q  <= accept && !legal_i;
      done_q <= adv && last;
      if (accept && legal_i) begin
        st_q   <= ST_WALK;
        addr_q <= start_i;
        mask_q <= mask_i;
        idx_q  <= '0;
        attr_q <= attr_i;
      end else if (adv) begin
        addr_q <= addr_q + 64'd8;
        idx_q  <= idx_q + 1'b1;
        if (last) st_q <= ST_IDLE;
      end
    end
  end

  assign hint_valid_o = (st_q == ST_WALK) && act;
  assign hint_addr_o  = addr_q;
  assign hint_attr_o  = attr_q;
  assign done_o       = done_q;
  assign illegal_o    = ill_q;
endmodule

// File: rtl/vec_prefetch_seq.sv
module vec_prefetch_seq
  import vpf_pkg::*;
#(
  parameter int VEC_BITS = 512,
  localparam int ELEMS = VEC_BITS / 64,
  localparam int PW = VEC_BITS / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [31:0]   insn_i,
  input  logic [63:0]   gpr_i,
  input  logic [63:0]   sp_i,
  input  logic [PW-1:0] pred_i,
  output logic [4:0]    rd_rn_o,
  output logic [2:0]    rd_pg_o,
  output logic          hint_valid_o,
  input  logic          hint_ready_i,
  output logic [63:0]   hint_addr_o,
  output logic          hint_write_o,
  output logic [1:0]    hint_level_o,
  output logic          hint_stream_o,
  output logic [3:0]    hint_op_o,
  output logic          hint_named_o,
  output logic          done_o,
  output logic          illegal_o
);
  dec_t             dec;
  logic [63:0]      start;
  logic [ELEMS-1:0] mask;
  hint_attr_t       attr;

  vpf_decode u_dec (.insn_i(insn_i), .dec_o(dec));

  vpf_addr_gen #(.ELEMS(ELEMS)) u_agen (
    .gpr_i(gpr_i), .sp_i(sp_i), .rn_i(dec.rn), .imm_i(dec.imm), .start_o(start)
  );

  vpf_lane_pick #(.ELEMS(ELEMS)) u_lane (.pred_i(pred_i), .mask_o(mask));

  vpf_walker #(.ELEMS(ELEMS)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .legal_i     (dec.legal),
    .start_i     (start),
    .mask_i      (mask),
    .attr_i      (dec.attr),
    .idle_o      (req_ready_o),
    .hint_valid_o(hint_valid_o),
    .hint_ready_i(hint_ready_i),
    .hint_addr_o (hint_addr_o),
    .hint_attr_o (attr),
    .done_o      (done_o),
    .illegal_o   (illegal_o)
  );

  assign rd_rn_o       = dec.rn;
  assign rd_pg_o       = dec.pg;
  assign hint_write_o  = attr.write;
  assign hint_level_o  = attr.level;
  assign hint_stream_o = attr.stream;
  assign hint_op_o     = attr.op;
  assign hint_named_o  = attr.named;
endmodule

// File: rtl/vpf_chk.sv
module vpf_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_ready_o,
  input logic        hint_valid_o,
  input logic        hint_ready_i,
  input logic [63:0] hint_addr_o,
  input logic [3:0]  hint_op_o,
  input logic        done_o,
  input logic        illegal_o
);
  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hint_valid_o && !hint_ready_i |=> hint_valid_o && $stable(hint_addr_o) && $stable(hint_op_o));

  // R10
  busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hint_valid_o |-> !req_ready_o);

  // R1
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> req_ready_o && !hint_valid_o && !done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o && !hint_valid_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind vec_prefetch_seq vpf_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .hint_valid_o(hint_valid_o),
  .hint_ready_i(hint_ready_i),
  .hint_addr_o (hint_addr_o),
  .hint_op_o   (hint_op_o),
  .done_o      (done_o),
  .illegal_o   (illegal_o)
);

// File: tb/sim_vec_prefetch_seq.sv
`timescale 1ns/1ps
module sim_vec_prefetch_seq;
  localparam int VEC_BITS = 512;
  localparam int N = VEC_BITS / 64;
  localparam int PW = VEC_BITS / 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic req_ready_o;
  logic [31:0] insn_i = '0;
  logic [63:0] gpr_i = '0, sp_i = '0;
  logic [PW-1:0] pred_i = '0;
  logic [4:0] rd_rn_o;
  logic [2:0] rd_pg_o;
  logic hint_valid_o, hint_ready_i = 1'b1;
  logic [63:0] hint_addr_o;
  logic hint_write_o, hint_stream_o, hint_named_o, done_o, illegal_o;
  logic [1:0] hint_level_o;
  logic [3:0] hint_op_o;

  always #2.5 clk = ~clk;

  vec_prefetch_seq #(.VEC_BITS(VEC_BITS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .insn_i(insn_i), .gpr_i(gpr_i), .sp_i(sp_i), .pred_i(pred_i),
    .rd_rn_o(rd_rn_o), .rd_pg_o(rd_pg_o), .hint_valid_o(hint_valid_o),
    .hint_ready_i(hint_ready_i), .hint_addr_o(hint_addr_o), .hint_write_o(hint_write_o),
    .hint_level_o(hint_level_o), .hint_stream_o(hint_stream_o), .hint_op_o(hint_op_o),
    .hint_named_o(hint_named_o), .done_o(done_o), .illegal_o(illegal_o)
  );

  typedef struct { logic [63:0] a; logic [3:0] op; } exp_t;
  exp_t exp_q[$];

  int checks = 0, fails = 0;
  bit exp_illegal = 1'b0;
  bit rand_ready = 1'b0;
  bit stall_prev = 1'b0;
  logic [63:0] prev_addr = '0;
  logic [3:0] prev_op = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic logic [31:0] mk(input logic [5:0] imm, input logic [2:0] pg,
                                     input logic [4:0] rn, input logic [3:0] op);
    return {10'b1000010111, imm, 3'b011, pg, rn, 1'b0, op};
  endfunction

  function automatic logic [63:0] start_of(input logic [63:0] base, input logic [5:0] imm);
    logic signed [63:0] s;
    s = 64'($signed(imm));
    return base + 64'((s * N) * 8);
  endfunction

  // ready throttle
  always @(posedge clk) begin
    #1;
    hint_ready_i = rand_ready ? 1'($urandom % 2) : 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (stall_prev) begin
        chk(hint_valid_o, "R8", "valid held", 64'(hint_valid_o), 64'd1);
        chk(hint_addr_o == prev_addr, "R8", "addr held", hint_addr_o, prev_addr);
        chk(hint_op_o == prev_op, "R8", "op held", 64'(hint_op_o), 64'(prev_op));
      end
      if (hint_valid_o) chk(!req_ready_o, "R10", "ready while busy", 64'(req_ready_o), 64'd0);
      if (hint_valid_o && hint_ready_i) begin
        if (exp_q.size() == 0) chk(1'b0, "R5", "spurious hint", hint_addr_o, 64'd0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(hint_addr_o == e.a, "R4", "hint addr", hint_addr_o, e.a);
          chk(hint_op_o == e.op, "R6", "raw op", 64'(hint_op_o), 64'(e.op));
          chk(hint_write_o == e.op[3], "R6", "write", 64'(hint_write_o), 64'(e.op[3]));
          chk(hint_level_o == e.op[2:1], "R6", "level", 64'(hint_level_o), 64'(e.op[2:1]));
          chk(hint_stream_o == e.op[0], "R6", "stream", 64'(hint_stream_o), 64'(e.op[0]));
          chk(hint_named_o == (e.op[2:1] != 2'b11), "R7", "named", 64'(hint_named_o),
              64'(e.op[2:1] != 2'b11));
        end
      end
      if (done_o) chk(exp_q.size() == 0, "R9", "done with hints pending", 64'(exp_q.size()), 64'd0);
      if (illegal_o) chk(exp_illegal, "R1", "unexpected illegal", 64'd1, 64'd0);
      stall_prev = hint_valid_o && !hint_ready_i;
      prev_addr  = hint_addr_o;
      prev_op    = hint_op_o;
    end
  end

  task automatic issue(input logic [31:0] insn, input logic [63:0] gpr, input logic [63:0] sp,
                       input logic [PW-1:0] pred, input int exp_cyc);
    bit legal;
    logic [63:0] st;
    int n;
    legal = (insn[31:22] == 10'b1000010111) && (insn[15:13] == 3'b011) && !insn[4];
    @(posedge clk); #1;
    while (!req_ready_o) begin @(posedge clk); #1; end
    insn_i = insn; gpr_i = gpr; sp_i = sp; pred_i = pred; req_valid_i = 1'b1;
    #0.1;
    chk(rd_rn_o == insn[9:5], "R3", "rn select", 64'(rd_rn_o), 64'(insn[9:5]));
    chk(rd_pg_o == insn[12:10], "R3", "pg select", 64'(rd_pg_o), 64'(insn[12:10]));
    st = start_of((insn[9:5] == 5'd31) ? sp : gpr, insn[21:16]);  // R2 R3
    if (legal) begin
      for (int e = 0; e < N; e++)
        if (pred[e*8]) exp_q.push_back('{a: st + 64'(8*e), op: insn[3:0]});
    end else exp_illegal = 1'b1;
    @(posedge clk); #1;
    req_valid_i = 1'b0;
    if (!legal) begin
      chk(req_ready_o, "R1", "stays idle", 64'(req_ready_o), 64'd1);
      @(negedge clk);
      chk(illegal_o, "R1", "illegal flag", 64'(illegal_o), 64'd1);
      chk(!hint_valid_o && !done_o, "R1", "no output", 64'(hint_valid_o), 64'd0);
      @(posedge clk); #1;
      exp_illegal = 1'b0;
      @(negedge clk);
      chk(!illegal_o, "R1", "one-cycle flag", 64'(illegal_o), 64'd0);
      chk(!done_o, "R1", "no done", 64'(done_o), 64'd0);
    end else begin
      chk(!req_ready_o, "R10", "busy after accept", 64'(req_ready_o), 64'd0);
      n = 0;
      do begin @(negedge clk); n++; end while (!done_o && n < 2000);
      chk(done_o, "R9", "done seen", 64'(done_o), 64'd1);
      if (exp_cyc > 0) chk(n == exp_cyc, "R11", "done cycle", 64'(n), 64'(exp_cyc));
      chk(exp_q.size() == 0, "R5", "all hints seen", 64'(exp_q.size()), 64'd0);
      @(negedge clk);
      chk(!done_o, "R9", "done one cycle", 64'(done_o), 64'd0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "R9", "watchdog expired", 64'(checks), 64'd0);
    summary();
  end

  initial begin
    logic [PW-1:0] off_lane;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < PW; i++) off_lane[i] = (i % 8) != 0;
    #12 rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o, "R10", "reset idle", 64'(req_ready_o), 64'd1);
    chk(!hint_valid_o && !done_o && !illegal_o, "R9", "reset quiet", 64'(hint_valid_o), 64'd0);

    // full and empty predicates at full rate
    issue(mk(6'd0, 3'd1, 5'd3, 4'd0), 64'h1000, 64'h9000, '1, N + 1);           // R11
    issue(mk(6'd2, 3'd2, 5'd4, 4'd1), 64'h2000, 64'h9000, '0, N + 1);           // R9
    issue(mk(6'd1, 3'd0, 5'd5, 4'd2), 64'h3000, 64'h9000, off_lane, N + 1);     // R5
    issue(mk(6'b100000, 3'd3, 5'd31, 4'd9), 64'h4000, 64'h8000_0000, '1, N + 1); // R3 R2
    issue(mk(6'd31, 3'd4, 5'd7, 4'd12), 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, '1, N + 1); // R2 wrap
    issue(mk(6'h3F, 3'd4, 5'd7, 4'd5), 64'h0000_0000_0000_0100, 64'h0, '1, N + 1);  // R2 -1

    // sparse predicate under stalls: addresses keep slots of skipped lanes
    rand_ready = 1'b1;
    issue(mk(6'd3, 3'd5, 5'd8, 4'd3), 64'hABC0, 64'h0, PW'(64'h0100_0000_0000_0001), 0); // R4
    for (int op = 0; op < 16; op++)                                                    // R6 R7
      issue(mk(6'($urandom), 3'($urandom), 5'($urandom), 4'(op)),
            {$urandom, $urandom}, {$urandom, $urandom}, PW'({$urandom, $urandom}), 0);

    // bad encodings: R1
    issue(mk(6'd0, 3'd0, 5'd1, 4'd0) ^ 32'h8000_0000, 64'h10, 64'h0, '1, 0);
    issue(mk(6'd0, 3'd0, 5'd1, 4'd0) ^ 32'h0040_0000, 64'h10, 64'h0, '1, 0);
    issue(mk(6'd0, 3'd0, 5'd1, 4'd0) ^ 32'h0000_4000, 64'h10, 64'h0, '1, 0);
    issue(mk(6'd0, 3'd0, 5'd1, 4'd0) | 32'h0000_0010, 64'h10, 64'h0, '1, 0);

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [31:0] w;
      w = mk(6'($urandom), 3'($urandom), 5'($urandom), 4'($urandom));
      if ($urandom % 10 == 0) w = w ^ (32'd1 << ($urandom % 32));
      issue(w, {$urandom, $urandom}, {$urandom, $urandom}, PW'({$urandom, $urandom}), 0);
    end
    rand_ready = 1'b0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule